// File: doc/BRIEF.md
# Clock Multiplier Configuration and Ready Controller

This block is the register-side control of a clock-multiplying loop. Software writes a single control word that holds the reference source choice, the multiplication factor, the output divide factor, an enable bit, an interrupt enable bit and an interrupt clear bit. The analog loop itself is not modelled. A counter of reference cycles stands in for its lock time, and a second short counter models the time the loop takes to stop.

While the loop is enabled, or while it is still winding down after a disable, the block freezes the source, multiplier and divider fields. Software must therefore clear the enable bit, wait for the ready flag to fall, write the new fields, and then set the enable bit again. The block raises a sticky interrupt when ready rises, if the interrupt enable bit is set. It gates a downstream clock-enable with ready and enable.

The block also checks the current fields without a clock. It flags an illegal reference frequency, a loop frequency above the limit of the selected supply voltage range, and a system clock above its ceiling. It reports whether the loop frequency suits a fixed divide-by-two clock for a 48 MHz peripheral. It does not build any clock itself.

Top module: `clkmul_ctrl`

## Requirements
- R1: After reset, ready, irq and clk_en are 0, src_sel is 0, and mul_sel and div_sel are 0.
- R2: The wr_data layout is bit 0 enable, bit 1 interrupt enable, bit 2 interrupt clear, bit 3 source, then MUL_W bits of multiplier, then DIV_W bits of divide field. Source 0 selects the internal reference (INT_MHZ, default 16) and source 1 selects the external one (EXT_MHZ, default 8). A write while enable and ready are both 0 updates src_sel, mul_sel and div_sel at the write edge.
- R3: A write made while the held enable bit is 1, or while ready is 1 during the stop delay, leaves src_sel, mul_sel and div_sel unchanged. The enable and interrupt enable bits are always written.
- R4: ready rises on the (LOCK_CYCLES+1)-th clock edge after the edge that sets enable, and stays 0 before that edge.
- R5: When enable is cleared, ready stays 1 and falls on the (STOP_CYCLES+1)-th edge after the clearing edge.
- R6: irq becomes 1 one edge after ready rises if the interrupt enable bit is 1. It stays 0 if that bit is 0.
- R7: irq stays 1 until a write with bit 2 set. If that write lands on the same edge that sets irq, irq is 1.
- R8: err_vco is 1 when reference MHz × mul_sel exceeds 96 for vrange 1, 48 for vrange 2, or 24 for vrange 3 and vrange 0.
- R9: err_sys is 1 when the loop frequency divided by (div_sel+1) exceeds 32 MHz.
- R10: err_ref is 1 when the selected reference frequency is outside 2 to 24 MHz.
- R11: usb_ok is 1 exactly when the loop frequency equals 96 MHz.
- R12: clk_en is 1 only while both ready and the held enable bit are 1, and it falls at the edge that clears enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4+MUL_W+DIV_W | Control word |
| vrange | input | 2 | Supply voltage range code (1, 2, 3; 0 treated as 3) |
| src_sel | output | 1 | Held source choice |
| mul_sel | output | MUL_W | Held multiplication factor |
| div_sel | output | DIV_W | Held divide field (divide by value+1) |
| ready | output | 1 | Loop ready flag |
| irq | output | 1 | Sticky ready interrupt |
| clk_en | output | 1 | Gated clock enable |
| err_ref | output | 1 | Reference frequency out of range |
| err_vco | output | 1 | Loop frequency above range limit |
| err_sys | output | 1 | System clock above ceiling |
| usb_ok | output | 1 | Loop frequency suits the divide-by-two peripheral clock |

## Verification
The legality checks are tried on a 96 MHz setting under each voltage range, on a divide setting that pushes the system clock to 48 MHz, and on an external 24 MHz setting. Together these separate the range limit from the system ceiling and from the peripheral match. Field writes are tried while unlocked, while enabled, and inside the stop delay, so that a lock that releases too early or too late shows up as a changed field. The ready timing is checked on both sides of each counted edge. The interrupt is run with its enable on and off, and with a clear that coincides with the set. A second instance with an out-of-range external reference exercises the reference check.

// File: rtl/clkmul_pkg.sv
package clkmul_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_LOCK, ST_RUN, ST_STOP} lock_st_t;
   localparam int BIT_ON     = 0;
   localparam int BIT_IE     = 1;
   localparam int BIT_ICLR   = 2;
   localparam int BIT_SRC    = 3;
   localparam int FIELD_BASE = 4;
endpackage

// File: rtl/clkmul_cfg.sv
module clkmul_cfg #(
   parameter int MUL_W = 4,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_on,
   input  logic             wr_ie,
   input  logic             wr_src,
   input  logic [MUL_W-1:0] wr_mul,
   input  logic [DIV_W-1:0] wr_div,
   input  logic             ready,
   output logic             on_q,
   output logic             ie_q,
   output logic             src_q,
   output logic [MUL_W-1:0] mul_q,
   output logic [DIV_W-1:0] div_q
);
   logic frozen;
   assign frozen = on_q | ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on_q  <= 1'b0;
         ie_q  <= 1'b0;
         src_q <= 1'b0;
         mul_q <= '0;
         div_q <= '0;
      end else if (wr_en) begin
         on_q <= wr_on;
         ie_q <= wr_ie;
         if (!frozen) begin
            src_q <= wr_src;
            mul_q <= wr_mul;
            div_q <= wr_div;
         end
      end
   end

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (on_q || ready) |=> $stable({src_q, mul_q, div_q})) else $error("fields moved while frozen"); // R3
endmodule

// File: rtl/clkmul_lock.sv
module clkmul_lock import clkmul_pkg::*; #(
   parameter int LOCK_CYCLES = 64,
   parameter int STOP_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic on,
   output logic ready
);
   localparam int MAXC = (LOCK_CYCLES > STOP_CYCLES) ? LOCK_CYCLES : STOP_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   lock_st_t      st, st_nxt;
   logic [CW-1:0] cnt, cnt_nxt;
   lock_st_t      run_exit;
   logic          stop_done;
   logic          lock_done;

   assign lock_done = (cnt == CW'(LOCK_CYCLES - 1));

   generate
      if (STOP_CYCLES == 0) begin : g_stop_none
         assign run_exit  = ST_IDLE;
         assign stop_done = 1'b1;
      end else begin : g_stop_timed
         assign run_exit  = ST_STOP;
         assign stop_done = (cnt == CW'(STOP_CYCLES - 1));
         AST_STOP_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(on) && ready) |=> ready) else $error("ready fell at once"); // R5
      end
   endgenerate

   always_comb begin
      st_nxt  = st;
      cnt_nxt = '0;
      unique case (st)
         ST_IDLE: if (on) st_nxt = ST_LOCK;
         ST_LOCK: begin
            if (!on)           st_nxt = ST_IDLE;
            else if (lock_done) st_nxt = ST_RUN;
            else               cnt_nxt = cnt + 1'b1;
         end
         ST_RUN:  if (!on) st_nxt = run_exit;
         ST_STOP: begin
            if (stop_done) st_nxt = ST_IDLE;
            else           cnt_nxt = cnt + 1'b1;
         end
         default: st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_nxt;
         cnt <= cnt_nxt;
      end
   end

   assign ready = (st == ST_RUN) || (st == ST_STOP);

   AST_READY_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> on) else $error("ready rose without enable"); // R4
endmodule

// File: rtl/clkmul_irq.sv
module clkmul_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic ready,
   input  logic ie,
   input  logic clr,
   output logic irq
);
   logic rdy_d;
   logic set_ev;

   assign set_ev = ready & ~rdy_d & ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_d <= 1'b0;
         irq   <= 1'b0;
      end else begin
         rdy_d <= ready;
         if (set_ev)   irq <= 1'b1;
         else if (clr) irq <= 1'b0;
      end
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ready && ie)) else $error("irq without cause"); // R6
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr) |=> irq) else $error("irq dropped without clear"); // R7
endmodule

// File: rtl/clkmul_legal.sv
module clkmul_legal #(
   parameter int INT_MHZ = 16,
   parameter int EXT_MHZ = 8,
   parameter int MUL_W   = 4,
   parameter int DIV_W   = 2,
   parameter int REF_MIN = 2,
   parameter int REF_MAX = 24,
   parameter int LIM_R1  = 96,
   parameter int LIM_R2  = 48,
   parameter int LIM_R3  = 24,
   parameter int SYS_MAX = 32,
   parameter int USB_VCO = 96
) (
   input  logic             src,
   input  logic [MUL_W-1:0] mul,
   input  logic [DIV_W-1:0] div,
   input  logic [1:0]       vrange,
   output logic             err_ref,
   output logic             err_vco,
   output logic             err_sys,
   output logic             usb_ok
);
   int unsigned ref_mhz, vco_mhz, lim, div_n;

   always_comb begin
      ref_mhz = src ? 32'(EXT_MHZ) : 32'(INT_MHZ);
      vco_mhz = ref_mhz * 32'(mul);
      div_n   = 32'(div) + 32'd1;
      unique case (vrange)
         2'd1:    lim = 32'(LIM_R1);
         2'd2:    lim = 32'(LIM_R2);
         default: lim = 32'(LIM_R3);
      endcase
      err_ref = (ref_mhz < 32'(REF_MIN)) || (ref_mhz > 32'(REF_MAX));
      err_vco = vco_mhz > lim;
      err_sys = vco_mhz > (32'(SYS_MAX) * div_n);
      usb_ok  = (vco_mhz == 32'(USB_VCO));
   end
endmodule

// File: rtl/clkmul_ctrl.sv
module clkmul_ctrl import clkmul_pkg::*; #(
   parameter int MUL_W       = 4,
   parameter int DIV_W       = 2,
   parameter int INT_MHZ     = 16,
   parameter int EXT_MHZ     = 8,
   parameter int LOCK_CYCLES = 64,
   parameter int STOP_CYCLES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [FIELD_BASE+MUL_W+DIV_W-1:0] wr_data,
   input  logic [1:0]                    vrange,
   output logic                          src_sel,
   output logic [MUL_W-1:0]              mul_sel,
   output logic [DIV_W-1:0]              div_sel,
   output logic                          ready,
   output logic                          irq,
   output logic                          clk_en,
   output logic                          err_ref,
   output logic                          err_vco,
   output logic                          err_sys,
   output logic                          usb_ok
);
   localparam int MUL_LSB = FIELD_BASE;
   localparam int DIV_LSB = FIELD_BASE + MUL_W;

   initial begin
      assert (LOCK_CYCLES >= 1) else $error("LOCK_CYCLES must be at least 1");
      assert (STOP_CYCLES >= 0) else $error("STOP_CYCLES must not be negative");
      assert (MUL_W >= 1 && DIV_W >= 1) else $error("field widths must be positive");
      assert (INT_MHZ > 0 && EXT_MHZ > 0) else $error("reference frequencies must be positive");
   end

   logic on_q, ie_q, irq_clr;

   assign irq_clr = wr_en & wr_data[BIT_ICLR];

   clkmul_cfg #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_on(wr_data[BIT_ON]), .wr_ie(wr_data[BIT_IE]), .wr_src(wr_data[BIT_SRC]),
      .wr_mul(wr_data[MUL_LSB +: MUL_W]), .wr_div(wr_data[DIV_LSB +: DIV_W]),
      .ready(ready), .on_q(on_q), .ie_q(ie_q),
      .src_q(src_sel), .mul_q(mul_sel), .div_q(div_sel)
   );

   clkmul_lock #(.LOCK_CYCLES(LOCK_CYCLES), .STOP_CYCLES(STOP_CYCLES)) u_lock (
      .clk(clk), .rst_n(rst_n), .on(on_q), .ready(ready)
   );

   clkmul_irq u_irq (
      .clk(clk), .rst_n(rst_n), .ready(ready), .ie(ie_q), .clr(irq_clr), .irq(irq)
   );

   clkmul_legal #(.INT_MHZ(INT_MHZ), .EXT_MHZ(EXT_MHZ), .MUL_W(MUL_W), .DIV_W(DIV_W)) u_legal (
      .src(src_sel), .mul(mul_sel), .div(div_sel), .vrange(vrange),
      .err_ref(err_ref), .err_vco(err_vco), .err_sys(err_sys), .usb_ok(usb_ok)
   );

   assign clk_en = ready & on_q;

   AST_CLKEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !clk_en) else $error("clock enable without ready"); // R12
endmodule

// File: tb/test_clkmul_ctrl.sv
module test_clkmul_ctrl;
   localparam int LOCKN = 64;
   localparam int STOPN = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [9:0] wr_data = '0;
   logic [1:0] vrange = 2'd1;
   logic src_sel, ready, irq, clk_en, err_ref, err_vco, err_sys, usb_ok;
   logic [3:0] mul_sel;
   logic [1:0] div_sel;
   logic h_src, h_rdy, h_irq, h_ce, h_eref, h_evco, h_esys, h_usb;
   logic [3:0] h_mul;
   logic [1:0] h_div;

   always #2.5 clk = ~clk;

   clkmul_ctrl i_clkmul_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .vrange(vrange),
      .src_sel(src_sel), .mul_sel(mul_sel), .div_sel(div_sel), .ready(ready), .irq(irq),
      .clk_en(clk_en), .err_ref(err_ref), .err_vco(err_vco), .err_sys(err_sys), .usb_ok(usb_ok)
   );

   clkmul_ctrl #(.EXT_MHZ(30)) i_clkmul_ctrl_hot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .vrange(vrange),
      .src_sel(h_src), .mul_sel(h_mul), .div_sel(h_div), .ready(h_rdy), .irq(h_irq),
      .clk_en(h_ce), .err_ref(h_eref), .err_vco(h_evco), .err_sys(h_esys), .usb_ok(h_usb)
   );

   localparam int S_READY = 0, S_IRQ = 1, S_CLKEN = 2, S_EVCO = 3, S_ESYS = 4,
                  S_EREF = 5, S_USB = 6, S_SRC = 7, S_MUL = 8, S_DIV = 9, S_EREF_HOT = 10;

   typedef struct {
      int    at;
      int    sig;
      int    exp;
      string tag;
   } item_t;

   item_t q[$];
   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int get_sig(int s);
      case (s)
         S_READY:    return int'(ready);
         S_IRQ:      return int'(irq);
         S_CLKEN:    return int'(clk_en);
         S_EVCO:     return int'(err_vco);
         S_ESYS:     return int'(err_sys);
         S_EREF:     return int'(err_ref);
         S_USB:      return int'(usb_ok);
         S_SRC:      return int'(src_sel);
         S_MUL:      return int'(mul_sel);
         S_DIV:      return int'(div_sel);
         S_EREF_HOT: return int'(h_eref);
         default:    return -1;
      endcase
   endfunction

   // monitor: compares queued expectations in the cycle they fall due
   always @(negedge clk) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
         if (q[i].at == cyc) begin
            int act;
            act = get_sig(q[i].sig);
            total++;
            if (act != q[i].exp) begin
               bad++;
               $display("FAIL %s sig=%0d cyc=%0d actual=%0d expected=%0d",
                        q[i].tag, q[i].sig, cyc, act, q[i].exp);
            end
            q.delete(i);
         end
      end
   end

   task automatic expect_at(int at, int sig, int exp, string tag);
      item_t it;
      it.at = at; it.sig = sig; it.exp = exp; it.tag = tag;
      q.push_back(it);
   endtask

   function automatic logic [9:0] mk(bit en, bit ie, bit clr, bit src, int mul, int dv);
      return {2'(dv), 4'(mul), src, clr, ie, en};
   endfunction

   // driver: one write, returns the cycle index of its edge
   task automatic wr(logic [9:0] d, output int w);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      w = cyc;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      int w;
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      expect_at(cyc + 1, S_READY, 0, "R1 ready");
      expect_at(cyc + 1, S_IRQ, 0, "R1 irq");
      expect_at(cyc + 1, S_CLKEN, 0, "R1 clk_en");
      expect_at(cyc + 1, S_SRC, 0, "R1 src");
      expect_at(cyc + 1, S_MUL, 0, "R1 mul");
      expect_at(cyc + 1, S_DIV, 0, "R1 div");
      idle(3);

      // internal 16 MHz x6 = 96, /3 = 32
      wr(mk(0, 1, 0, 0, 6, 2), w);
      expect_at(w, S_MUL, 6, "R2 mul");
      expect_at(w, S_DIV, 2, "R2 div");
      expect_at(w, S_SRC, 0, "R2 src");
      expect_at(w, S_EVCO, 0, "R8 96 in range 1");
      expect_at(w, S_ESYS, 0, "R9 32 MHz at limit");
      expect_at(w, S_USB, 1, "R11 96 MHz");
      expect_at(w, S_EREF, 0, "R10 internal ok");
      idle(2);

      @(negedge clk); vrange = 2'd2;
      expect_at(cyc + 1, S_EVCO, 1, "R8 96 in range 2");
      idle(2);
      @(negedge clk); vrange = 2'd3;
      expect_at(cyc + 1, S_EVCO, 1, "R8 96 in range 3");
      idle(2);
      @(negedge clk); vrange = 2'd1;
      idle(2);

      wr(mk(0, 1, 0, 0, 6, 1), w);
      expect_at(w, S_ESYS, 1, "R9 48 MHz system clock");
      idle(2);
      wr(mk(0, 1, 0, 0, 6, 2), w);
      idle(2);

      // enable with interrupt on
      wr(mk(1, 1, 0, 0, 6, 2), w);
      expect_at(w + LOCKN, S_READY, 0, "R4 ready before lock");
      expect_at(w + LOCKN + 1, S_READY, 1, "R4 ready at lock");
      expect_at(w + LOCKN, S_CLKEN, 0, "R12 clk_en before lock");
      expect_at(w + LOCKN + 1, S_CLKEN, 1, "R12 clk_en at lock");
      expect_at(w + LOCKN + 1, S_IRQ, 0, "R6 irq lags ready");
      expect_at(w + LOCKN + 2, S_IRQ, 1, "R6 irq set");
      idle(LOCKN + 6);

      wr(mk(1, 1, 0, 1, 3, 0), w);
      expect_at(w, S_SRC, 0, "R3 src frozen while enabled");
      expect_at(w, S_MUL, 6, "R3 mul frozen while enabled");
      expect_at(w, S_DIV, 2, "R3 div frozen while enabled");
      expect_at(w + 3, S_IRQ, 1, "R7 irq sticky");
      idle(5);
      wr(mk(1, 1, 1, 0, 6, 2), w);
      expect_at(w, S_IRQ, 0, "R7 irq cleared");
      idle(2);

      // disable: staged drop
      wr(mk(0, 1, 0, 0, 6, 2), w);
      expect_at(w, S_CLKEN, 0, "R5 R12 clk_en drops at once");
      expect_at(w + STOPN, S_READY, 1, "R5 ready held");
      expect_at(w + STOPN + 1, S_READY, 0, "R5 ready falls");
      wr(mk(0, 1, 0, 1, 3, 0), w);
      expect_at(w, S_SRC, 0, "R3 src frozen during stop");
      expect_at(w, S_MUL, 6, "R3 mul frozen during stop");
      idle(STOPN + 4);

      wr(mk(0, 1, 0, 1, 3, 0), w);
      expect_at(w, S_SRC, 1, "R2 external source");
      expect_at(w, S_MUL, 3, "R2 mul after stop");
      expect_at(w, S_EVCO, 0, "R8 24 in range 1");
      expect_at(w, S_USB, 0, "R11 24 MHz");
      expect_at(w, S_EREF, 0, "R10 8 MHz legal");
      expect_at(w, S_EREF_HOT, 1, "R10 30 MHz illegal");
      expect_at(w, S_IRQ, 0, "R6 no irq on ready fall");
      idle(2);

      // enable with interrupt off
      wr(mk(1, 0, 0, 1, 3, 0), w);
      expect_at(w + LOCKN + 1, S_READY, 1, "R4 relock");
      expect_at(w + LOCKN + 2, S_IRQ, 0, "R6 irq masked");
      expect_at(w + LOCKN + 4, S_IRQ, 0, "R6 irq masked later");
      idle(LOCKN + 6);

      wr(mk(0, 0, 0, 1, 3, 0), w);
      idle(STOPN + 4);

      // set and clear on the same edge
      wr(mk(1, 1, 0, 1, 3, 0), w);
      for (int k = 0; k < LOCKN + 10 && !ready; k++) @(negedge clk);
      wr_en = 1'b1;
      wr_data = mk(1, 1, 1, 1, 3, 0);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      w = cyc;
      expect_at(w, S_IRQ, 1, "R7 set beats clear");
      expect_at(w + 1, S_IRQ, 1, "R7 held after tie");
      idle(3);
      wr(mk(1, 1, 1, 1, 3, 0), w);
      expect_at(w, S_IRQ, 0, "R7 later clear");
      idle(4);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule